// File: doc/BRIEF.md
# Serial Control Register Bank

This block accepts configuration words over a three-wire serial port (a bit clock, a data line and a load strobe). It keeps eight 8-bit control registers and presents their contents as decoded control fields. These fields are per-colour gain and offset, power down, digital reset, reference selects, coupling, polarity, channel configuration, output disable and offset range. The serial port listens only while the line-start strobe is high. While the port is listening, the block asks the shared data bus to float.

Every serial input is brought into the system clock domain through a synchroniser and then edge-detected. A frame starts when the load strobe falls. Bits are shifted in on rising bit-clock edges. The frame commits to the addressed register on the rising load edge, but only when a full 11-bit word arrived. Two rules rewrite the register contents. Setting the reset bit restores every register to its default. Leaving power down clears the channel-configuration field.

Top module: `serctl_bank`

## Requirements
- R1: The port is enabled only while `line_sync_i` is high, and `bus_float_o` follows the synchronised `line_sync_i`. A frame sent while `line_sync_i` is low changes no register.
- R2: A frame begins on a falling `ser_load_i`. `ser_data_i` is taken on each rising `ser_clk_i`, most significant bit first. The first 3 bits are the register address and the next 8 are the data.
- R3: The addressed register is written at the rising `ser_load_i`, and only if at least 11 bit-clock rises were seen since the frame began. A shorter frame writes nothing.
- R4: Bit-clock rises after the eleventh in a frame are ignored, and only the first 11 bits are used.
- R5: Registers 0, 2 and 4 are the red, green and blue gains, and each gain output is data bits 7:2. Registers 1, 3 and 5 are the red, green and blue offsets, and each offset output is all 8 bits.
- R6: After `rst_n` every gain reads 0, every offset reads 8'h40, and registers 6 and 7 read 8'h00.
- R7: Register 6 decodes as follows: bit 7 power down, bit 6 digital reset, bit 5 top-reference external, bit 4 DC-reference external, bit 3 AC coupling, bit 2 inverted polarity, bits 1:0 channel configuration.
- R8: Register 7 bit 6 drives `out_disable_o` and bit 5 drives `ofs_range_o`.
- R9: A write that sets register 6 bit 6 raises `dig_reset_o` for exactly one cycle. In the cycle after, every register holds its default value.
- R10: A write to register 6 that clears bit 7 while power down is set stores 00 in bits 1:0, whatever those data bits were. The other fields take the written data.
- R11: If `line_sync_i` falls before the frame completes, the frame is abandoned and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_sync_i | input | 1 | Line-start strobe; high enables the serial port |
| ser_clk_i | input | 1 | Serial bit clock |
| ser_data_i | input | 1 | Serial data |
| ser_load_i | input | 1 | Load strobe, low during a frame |
| bus_float_o | output | 1 | Shared data bus must be high impedance |
| gain_red_o | output | 6 | Red gain code |
| gain_grn_o | output | 6 | Green gain code |
| gain_blu_o | output | 6 | Blue gain code |
| ofs_red_o | output | 8 | Red offset code |
| ofs_grn_o | output | 8 | Green offset code |
| ofs_blu_o | output | 8 | Blue offset code |
| pwr_down_o | output | 1 | Power down |
| dig_reset_o | output | 1 | One-cycle register reset pulse |
| vtop_ext_o | output | 1 | Top reference external |
| dcref_ext_o | output | 1 | DC reference external |
| ac_couple_o | output | 1 | AC coupling selected |
| invert_o | output | 1 | Inverted signal polarity |
| chan_cfg_o | output | 2 | Channel configuration |
| out_disable_o | output | 1 | Data outputs disabled |
| ofs_range_o | output | 1 | Offset DAC range select |

## Verification
The bench uses a fixed seed to draw random frames over all eight addresses. These frames are mixed with frames that are too short (8 to 10 bits), exactly 11 bits, and overlong (12 to 15 bits). A short frame that wrongly commits is told apart from an overlong frame that wrongly takes its trailing bits instead of the first eleven. Frames sent with the line strobe low, and frames cut off by a falling line strobe, separate gating by the enable from gating by the bit count. Directed sequences cover the power-down exit with channel configuration 11, and a digital reset written over non-default contents. These show the field-clearing rule apart from the whole-bank restore.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
  localparam int ADDR_W     = 3;
  localparam int DATA_W     = 8;
  localparam int NUM_REGS   = 1 << ADDR_W;
  localparam int FRAME_BITS = ADDR_W + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  localparam logic [ADDR_W-1:0] A_MODE = 3'd6;
  localparam logic [ADDR_W-1:0] A_TEST = 3'd7;

  localparam int B_PDOWN  = 7;
  localparam int B_DRESET = 6;

  function automatic logic [DATA_W-1:0] reg_default(input int idx);
    if (idx < 6 && (idx % 2) == 1) return 8'h40;
    return '0;
  endfunction
endpackage

// File: rtl/serctl_sync.sv
module serctl_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES:0] chain_q;
    logic [STAGES:0] chain_d;

    always_comb chain_d = {chain_q[STAGES-1:0], async_i[b]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= chain_d;
    end

    assign level_o[b] = chain_q[STAGES-1];
    assign rise_o[b]  = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall_o[b]  = ~chain_q[STAGES-1] & chain_q[STAGES];
  end
endmodule

// File: rtl/serctl_frame.sv
module serctl_frame
  import serctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              bit_rise_i,
  input  logic              bit_val_i,
  input  logic              load_fall_i,
  input  logic              load_rise_i,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic                  active_q, active_d;
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [FRAME_BITS-1:0] shift_q, shift_d;
  logic                  stb_q, stb_d;

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    shift_d  = shift_q;
    stb_d    = 1'b0;
    if (!en_i) begin
      active_d = 1'b0;
    end else if (load_fall_i) begin
      active_d = 1'b1;
      cnt_d    = '0;
    end else if (active_q) begin
      if (load_rise_i) begin
        active_d = 1'b0;
        stb_d    = (cnt_q == CNT_W'(FRAME_BITS));
      end else if (bit_rise_i && cnt_q < CNT_W'(FRAME_BITS)) begin
        shift_d = {shift_q[FRAME_BITS-2:0], bit_val_i};
        cnt_d   = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      shift_q  <= '0;
      stb_q    <= 1'b0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      shift_q  <= shift_d;
      stb_q    <= stb_d;
    end
  end

  assign wr_stb_o  = stb_q;
  assign wr_addr_o = shift_q[FRAME_BITS-1 -: ADDR_W];
  assign wr_data_o = shift_q[DATA_W-1:0];

  a_r4_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(FRAME_BITS));
  a_r1_no_commit_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !wr_stb_o);
  a_r3_commit_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |-> $past(load_rise_i));
endmodule

// File: rtl/serctl_regs.sv
module serctl_regs
  import serctl_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_stb_i,
  input  logic [ADDR_W-1:0]            wr_addr_i,
  input  logic [DATA_W-1:0]            wr_data_i,
  output logic [NUM_REGS*DATA_W-1:0]   regs_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];
  logic [DATA_W-1:0] regs_d [NUM_REGS];
  logic              upd_en;
  logic              reset_req;

  assign reset_req = regs_q[A_MODE][B_DRESET];
  assign upd_en    = wr_stb_i | reset_req;

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) regs_d[i] = regs_q[i];
    if (reset_req) begin
      for (int i = 0; i < NUM_REGS; i++) regs_d[i] = reg_default(i);
    end else if (wr_stb_i) begin
      regs_d[wr_addr_i] = wr_data_i;
      if (wr_addr_i == A_MODE && regs_q[A_MODE][B_PDOWN] && !wr_data_i[B_PDOWN])
        regs_d[A_MODE][1:0] = reg_default(int'(A_MODE)) >> 0 & 2'b00;
    end
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      regs_q[r] <= reg_default(r);
      else if (upd_en) regs_q[r] <= regs_d[r];
    end
    assign regs_o[r*DATA_W +: DATA_W] = regs_q[r];
  end

  a_r9_reset_self_clears: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !regs_q[A_MODE][B_DRESET]);
  a_r9_offsets_restored: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> (regs_q[1] == 8'h40 && regs_q[3] == 8'h40 && regs_q[5] == 8'h40));
  a_r10_cfg_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb_i && !reset_req && wr_addr_i == A_MODE && regs_q[A_MODE][B_PDOWN] && !wr_data_i[B_PDOWN])
      |=> regs_q[A_MODE][1:0] == 2'b00);
  a_r3_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_stb_i && !reset_req) |=> $stable(regs_q[0]) && $stable(regs_q[7]));
endmodule

// File: rtl/serctl_bank.sv
module serctl_bank
  import serctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_sync_i,
  input  logic       ser_clk_i,
  input  logic       ser_data_i,
  input  logic       ser_load_i,
  output logic       bus_float_o,
  output logic [5:0] gain_red_o,
  output logic [5:0] gain_grn_o,
  output logic [5:0] gain_blu_o,
  output logic [7:0] ofs_red_o,
  output logic [7:0] ofs_grn_o,
  output logic [7:0] ofs_blu_o,
  output logic       pwr_down_o,
  output logic       dig_reset_o,
  output logic       vtop_ext_o,
  output logic       dcref_ext_o,
  output logic       ac_couple_o,
  output logic       invert_o,
  output logic [1:0] chan_cfg_o,
  output logic       out_disable_o,
  output logic       ofs_range_o
);
  localparam int NIN = 4;

  logic [NIN-1:0] lvl, rise, fall;
  logic wr_stb;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [NUM_REGS*DATA_W-1:0] regs;

  serctl_sync #(.WIDTH(NIN), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({ser_load_i, ser_data_i, ser_clk_i, line_sync_i}),
    .level_o(lvl), .rise_o(rise), .fall_o(fall));

  serctl_frame u_frame (
    .clk(clk), .rst_n(rst_n),
    .en_i(lvl[0]), .bit_rise_i(rise[1]), .bit_val_i(lvl[2]),
    .load_fall_i(fall[3]), .load_rise_i(rise[3]),
    .wr_stb_o(wr_stb), .wr_addr_o(wr_addr), .wr_data_o(wr_data));

  serctl_regs u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_stb_i(wr_stb), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .regs_o(regs));

  assign bus_float_o   = lvl[0];
  assign gain_red_o    = regs[0*8+2 +: 6];
  assign ofs_red_o     = regs[1*8 +: 8];
  assign gain_grn_o    = regs[2*8+2 +: 6];
  assign ofs_grn_o     = regs[3*8 +: 8];
  assign gain_blu_o    = regs[4*8+2 +: 6];
  assign ofs_blu_o     = regs[5*8 +: 8];
  assign pwr_down_o    = regs[6*8+7];
  assign dig_reset_o   = regs[6*8+6];
  assign vtop_ext_o    = regs[6*8+5];
  assign dcref_ext_o   = regs[6*8+4];
  assign ac_couple_o   = regs[6*8+3];
  assign invert_o      = regs[6*8+2];
  assign chan_cfg_o    = regs[6*8 +: 2];
  assign out_disable_o = regs[7*8+6];
  assign ofs_range_o   = regs[7*8+5];

  a_r9_pulse_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    dig_reset_o |=> !dig_reset_o);
  a_r6_gain_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    dig_reset_o |=> (gain_red_o == 6'd0 && gain_grn_o == 6'd0 && gain_blu_o == 6'd0));
endmodule

// File: tb/sim_serctl_bank.sv
module sim_serctl_bank;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_sync = 1'b0, sclk = 1'b0, sdat = 1'b0, sload = 1'b1;
  logic bus_float, pwr_down, dig_reset, vtop, dcref, acc, inv, odis, orng;
  logic [5:0] g_r, g_g, g_b;
  logic [7:0] o_r, o_g, o_b;
  logic [1:0] cfg;

  int n_chk = 0, n_bad = 0;
  int pulses_seen = 0, pulses_exp = 0, run_len = 0, long_pulse = 0;
  logic [7:0] m [8];

  always #(CLK_P/2) clk = ~clk;

  serctl_bank u0 (
    .clk(clk), .rst_n(rst_n), .line_sync_i(line_sync), .ser_clk_i(sclk),
    .ser_data_i(sdat), .ser_load_i(sload), .bus_float_o(bus_float),
    .gain_red_o(g_r), .gain_grn_o(g_g), .gain_blu_o(g_b),
    .ofs_red_o(o_r), .ofs_grn_o(o_g), .ofs_blu_o(o_b),
    .pwr_down_o(pwr_down), .dig_reset_o(dig_reset), .vtop_ext_o(vtop),
    .dcref_ext_o(dcref), .ac_couple_o(acc), .invert_o(inv), .chan_cfg_o(cfg),
    .out_disable_o(odis), .ofs_range_o(orng));

  always @(negedge clk) begin
    if (dig_reset) begin
      run_len++;
      if (run_len == 1) pulses_seen++;
      if (run_len > 1) long_pulse++;
    end else run_len = 0;
  end

  function automatic logic [7:0] dflt(input int i);
    return (i < 6 && i % 2 == 1) ? 8'h40 : 8'h00;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk(req, "gain_red R5", g_r, m[0][7:2]);
    chk(req, "ofs_red R5", o_r, m[1]);
    chk(req, "gain_grn R5", g_g, m[2][7:2]);
    chk(req, "ofs_grn R5", o_g, m[3]);
    chk(req, "gain_blu R5", g_b, m[4][7:2]);
    chk(req, "ofs_blu R5", o_b, m[5]);
    chk(req, "mode fields R7", {pwr_down, dig_reset, vtop, dcref, acc, inv, cfg}, m[6]);
    chk(req, "test fields R8", {odis, orng}, m[7][6:5]);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sends nbits from the MSB of stream; abort_at >= 0 drops line sync before that bit.
  task automatic send(input logic [15:0] stream, input int nbits, input logic sync_on,
                      input int abort_at);
    @(negedge clk); line_sync = sync_on;
    wait_clk(4);
    sload = 1'b0;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      if (i == abort_at) line_sync = 1'b0;
      sdat = stream[15-i];
      wait_clk(2);
      sclk = 1'b1;
      wait_clk(4);
      sclk = 1'b0;
      wait_clk(2);
    end
    wait_clk(4);
    sload = 1'b1;
    wait_clk(8);
    line_sync = 1'b0;
    wait_clk(4);
  endtask

  task automatic model(input logic [2:0] a, input logic [7:0] d, input int nbits,
                       input logic sync_on, input int abort_at);
    logic [7:0] v;
    if (!sync_on || nbits < 11 || (abort_at >= 0 && abort_at < nbits)) return;
    v = d;
    if (a == 3'd6 && m[6][7] && !d[7]) v[1:0] = 2'b00;
    m[a] = v;
    if (a == 3'd6 && v[6]) begin
      pulses_exp++;
      for (int i = 0; i < 8; i++) m[i] = dflt(i);
    end
  endtask

  task automatic frame(input logic [2:0] a, input logic [7:0] d, input int nbits,
                       input logic sync_on, input int abort_at, input logic [4:0] tail,
                       input string req);
    send({a, d, tail}, nbits, sync_on, abort_at);
    model(a, d, nbits, sync_on, abort_at);
    check_all(req);
  endtask

  initial begin : watchdog
    #(CLK_P * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd7321));
    for (int i = 0; i < 8; i++) m[i] = dflt(i);
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);
    check_all("R6 reset");
    chk("R1", "bus_float idle", bus_float, 0);
    @(negedge clk); line_sync = 1'b1;
    wait_clk(4);
    chk("R1", "bus_float active", bus_float, 1);
    line_sync = 1'b0;
    wait_clk(4);
    chk("R1", "bus_float released", bus_float, 0);

    frame(3'd0, 8'hFC, 11, 1'b1, -1, 5'h0, "R2 red gain max");
    frame(3'd3, 8'hA5, 11, 1'b1, -1, 5'h0, "R2 grn offset");
    frame(3'd4, 8'h33, 10, 1'b1, -1, 5'h0, "R3 short frame");
    frame(3'd5, 8'h81, 15, 1'b1, -1, 5'h1F, "R4 long frame");
    frame(3'd1, 8'h12, 11, 1'b0, -1, 5'h0, "R1 sync low");
    frame(3'd2, 8'h77, 11, 1'b1, 6, 5'h0, "R11 abort");
    frame(3'd7, 8'h60, 11, 1'b1, -1, 5'h0, "R8 test reg");
    frame(3'd6, 8'hBF, 11, 1'b1, -1, 5'h0, "R7 mode pd set");
    frame(3'd6, 8'h3F, 11, 1'b1, -1, 5'h0, "R10 pd clear");
    chk("R10", "cfg after pd exit", cfg, 0);
    chk("R10", "ac kept", acc, 1);
    frame(3'd6, 8'h40, 11, 1'b1, -1, 5'h0, "R9 digital reset");
    chk("R9", "dig_reset low after", dig_reset, 0);

    for (int k = 0; k < 150; k++) begin
      logic [2:0] a;
      logic [7:0] d;
      int nb, ab;
      logic so;
      a = 3'($urandom % 8);
      d = 8'($urandom);
      if (a == 3'd6) d[6] = (($urandom % 8) == 0);
      nb = (($urandom % 10) < 6) ? 11 : 8 + int'($urandom % 8);
      so = (($urandom % 10) != 0);
      ab = (($urandom % 20) == 0) ? int'($urandom % 11) : -1;
      frame(a, d, nb, so, ab, 5'($urandom), "R2 R3 R4 random");
    end

    chk("R9", "pulse count", pulses_seen, pulses_exp);
    chk("R9", "over-long pulses", long_pulse, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule